// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between the load/store stage of a 16-bit processor datapath and a 16-bit-wide synchronous RAM that has one enable per byte. It covers a linear, byte-addressed 64 KiB space. For each request it forms the effective address from a base register value and a signed displacement. If the base register index is zero, the base is taken as zero whatever value is presented. This one adder therefore gives indexed, register-indirect (zero displacement) and absolute (zero base) access.

Stores are steered onto the correct byte lane, with the matching byte enable raised. Loads are taken from the returned word, shifted down to the low byte when needed, and zero- or sign-extended. A word access to an odd address never reaches memory. Instead it raises a single-cycle fault, which the processor turns into an invalid-instruction trap. The memory is little-endian: address bit 0 selects the lane.

Top module: `byte_lane_lsu`

## Requirements
- R1: The effective address on `eff_addr` equals the base plus the 8-bit displacement sign-extended to 16 bits, modulo 65536, and appears in the cycle after the request.
- R2: When `base_idx` is 0 the base is treated as zero and `base_val` has no effect on the address.
- R3: A byte store (`req_word`=0) raises exactly one enable: `mem_be`=2'b01 for an even address and 2'b10 for an odd address. Both byte lanes of `mem_wdata` carry bits 7:0 of `st_data`.
- R4: A word store to an even address raises `mem_be`=2'b11 and drives `st_data` unchanged on `mem_wdata`.
- R5: An unsigned byte load (`req_signed`=0) returns the addressed byte in bits 7:0 of `ld_data` and zeros in bits 15:8.
- R6: A signed byte load (`req_signed`=1) fills bits 15:8 of `ld_data` with bit 7 of the addressed byte.
- R7: A word load from an even address returns the memory word unchanged, with the byte at the even address in bits 7:0.
- R8: A word access to an odd address drives no memory cycle. It raises `misalign_fault` for one cycle and sets `eff_addr` to the odd address. Byte accesses never fault.
- R9: `mem_en` is high in the cycle after an accepted request. `mem_waddr` is the effective address shifted right by one. `ld_valid` rises two cycles after the memory read cycle.
- R10: While reset is held, `mem_en`, `mem_we`, `mem_be`, `misalign_fault`, `ld_valid` and `eff_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_signed | input | 1 | Byte load extension: 1 = sign, 0 = zero |
| base_idx | input | 3 | Index of the base register; 0 means zero base |
| base_val | input | 16 | Value read from the base register |
| disp | input | 8 | Signed displacement |
| st_data | input | 16 | Store source register value |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write strobe |
| mem_be | output | 2 | Byte enables, bit 0 = low lane |
| mem_waddr | output | 15 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, valid one cycle after the read cycle |
| eff_addr | output | 16 | Effective byte address of the last request |
| misalign_fault | output | 1 | One-cycle fault for an odd word address |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 16 | Aligned and extended load result |

## Verification
Broken lane state shows up at the ports in one of two ways:
- A wrong enable, or a byte in the wrong lane, appears on the memory port in the cycle after the store.
- A lane or extension flag lost in the load pipeline changes `ld_data` two cycles after the read strobe.

A wrong misalignment decision shows as a memory strobe in place of a fault, or the reverse, in the cycle after the request. Reading back stored bytes through loads of both widths ties the write-side steering to the read-side extraction.

// File: rtl/blsu_pkg.sv
package blsu_pkg;
  // Width of one memory lane.
  localparam int unsigned LANE_W = 8;

  // Format carried alongside a pending load.
  typedef struct packed {
    logic is_word;
    logic sign_ext;
  } ld_fmt_t;
endpackage

// File: rtl/blsu_ea_calc.sv
module blsu_ea_calc #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    // Index zero is the hardwired-zero register.
    base_eff = (base_idx == '0) ? '0 : base_val;
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    ea       = base_eff + disp_ext;
  end
endmodule

// File: rtl/blsu_store_steer.sv
module blsu_store_steer #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / blsu_pkg::LANE_W,
  parameter int unsigned LSB_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              is_word,
  input  logic [LSB_W-1:0]  lane,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  import blsu_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      be[g] = is_word | (lane == LSB_W'(g));
      // A byte store copies the low source byte onto every lane.
      wdata[g*LANE_W +: LANE_W] = is_word ? src[g*LANE_W +: LANE_W]
                                          : src[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/blsu_load_extract.sv
module blsu_load_extract #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / blsu_pkg::LANE_W,
  parameter int unsigned LSB_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  blsu_pkg::ld_fmt_t fmt,
  input  logic [LSB_W-1:0]  lane,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] data
);
  import blsu_pkg::*;

  localparam int unsigned FILL_W = DATA_W - LANE_W;

  logic [LANE_W-1:0] lane_byte [LANES];
  logic [LANE_W-1:0] sel;
  logic              fill;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_byte[g] = rdata[g*LANE_W +: LANE_W];
  end

  always_comb begin
    sel  = lane_byte[lane];
    fill = fmt.sign_ext & sel[LANE_W-1];
    data = fmt.is_word ? rdata : {{FILL_W{fill}}, sel};
  end
endmodule

// File: rtl/byte_lane_lsu.sv
module byte_lane_lsu #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned IDX_W  = 3,
  localparam int unsigned LANES = DATA_W / blsu_pkg::LANE_W,
  localparam int unsigned LSB_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned WA_W  = ADDR_W - LSB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_signed,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] st_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [WA_W-1:0]   mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misalign_fault,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  import blsu_pkg::*;

  // Request-side combinational values.
  logic [ADDR_W-1:0] ea_d;
  logic [LSB_W-1:0]  lane_d;
  logic              odd_word_d;
  logic              go_d;
  logic              ld_go_d;
  logic [LANES-1:0]  be_d;
  logic [DATA_W-1:0] wdata_d;
  ld_fmt_t           fmt_d;

  // Command stage registers.
  logic              en_q, we_q, flt_q;
  logic [LANES-1:0]  be_q;
  logic [WA_W-1:0]   wa_q;
  logic [DATA_W-1:0] wd_q;
  logic [ADDR_W-1:0] ea_q;
  logic              pend_a_q;
  ld_fmt_t           fmt_a_q;
  logic [LSB_W-1:0]  lane_a_q;

  // Read-wait stage registers.
  logic              pend_b_q;
  ld_fmt_t           fmt_b_q;
  logic [LSB_W-1:0]  lane_b_q;

  // Result registers.
  logic              ldv_q;
  logic [DATA_W-1:0] ldd_q;
  logic [DATA_W-1:0] ldd_d;

  blsu_ea_calc #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .IDX_W  (IDX_W)
  ) ea_i (
    .base_idx (base_idx),
    .base_val (base_val),
    .disp     (disp),
    .ea       (ea_d)
  );

  blsu_store_steer #(
    .DATA_W (DATA_W)
  ) steer_i (
    .is_word (req_word),
    .lane    (lane_d),
    .src     (st_data),
    .be      (be_d),
    .wdata   (wdata_d)
  );

  blsu_load_extract #(
    .DATA_W (DATA_W)
  ) extract_i (
    .fmt   (fmt_b_q),
    .lane  (lane_b_q),
    .rdata (mem_rdata),
    .data  (ldd_d)
  );

  // Next-state decode.
  always_comb begin
    lane_d         = ea_d[LSB_W-1:0];
    odd_word_d     = req_word & (lane_d != '0);
    go_d           = req_valid & ~odd_word_d;
    ld_go_d        = go_d & ~req_write;
    fmt_d.is_word  = req_word;
    fmt_d.sign_ext = req_signed;
  end

  // Command stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      we_q  <= 1'b0;
      flt_q <= 1'b0;
      be_q  <= '0;
      wa_q  <= '0;
      wd_q  <= '0;
      ea_q  <= '0;
    end else begin
      en_q  <= go_d;
      flt_q <= req_valid & odd_word_d;
      if (req_valid) begin
        ea_q <= ea_d;
      end
      if (go_d) begin
        we_q <= req_write;
        be_q <= be_d;
        wa_q <= ea_d[ADDR_W-1:LSB_W];
        wd_q <= wdata_d;
      end else begin
        we_q <= 1'b0;
        be_q <= '0;
      end
    end
  end

  // Load tracking through the RAM latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a_q <= 1'b0;
      fmt_a_q  <= '0;
      lane_a_q <= '0;
      pend_b_q <= 1'b0;
      fmt_b_q  <= '0;
      lane_b_q <= '0;
    end else begin
      pend_a_q <= ld_go_d;
      if (ld_go_d) begin
        fmt_a_q  <= fmt_d;
        lane_a_q <= lane_d;
      end
      pend_b_q <= pend_a_q;
      if (pend_a_q) begin
        fmt_b_q  <= fmt_a_q;
        lane_b_q <= lane_a_q;
      end
    end
  end

  // Result capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldv_q <= 1'b0;
      ldd_q <= '0;
    end else begin
      ldv_q <= pend_b_q;
      if (pend_b_q) begin
        ldd_q <= ldd_d;
      end
    end
  end

  assign mem_en         = en_q;
  assign mem_we         = we_q;
  assign mem_be         = be_q;
  assign mem_waddr      = wa_q;
  assign mem_wdata      = wd_q;
  assign eff_addr       = ea_q;
  assign misalign_fault = flt_q;
  assign ld_valid       = ldv_q;
  assign ld_data        = ldd_q;
endmodule

// File: rtl/byte_lane_lsu_chk.sv
module byte_lane_lsu_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_word,
  input logic              mem_en,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_be,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              misalign_fault,
  input logic              ld_valid
);
  // A byte write enables only the lane named by address bit 0.
  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !(&mem_be)) |-> (mem_be == (eff_addr[0] ? 2'b10 : 2'b01)));

  // A full-word cycle only ever targets an even address.
  assert_word_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && (&mem_be)) |-> !eff_addr[0]);

  // A fault never coexists with a memory strobe and points at an odd address.
  assert_fault_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_fault |-> (!mem_en && eff_addr[0]));

  // A fault only follows a word request.
  assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_fault |-> $past(req_valid && req_word));

  // Every read strobe yields a result two cycles later.
  assert_load_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> ##2 ld_valid);

  // No result without a matching read strobe.
  assert_load_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_en && !mem_we, 2));

  // An active strobe always has at least one lane enabled.
  assert_strobe_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_be != '0));
endmodule

bind byte_lane_lsu byte_lane_lsu_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_word       (req_word),
  .mem_en         (mem_en),
  .mem_we         (mem_we),
  .mem_be         (mem_be),
  .eff_addr       (eff_addr),
  .misalign_fault (misalign_fault),
  .ld_valid       (ld_valid)
);

// File: tb/byte_lane_lsu_tb_top.sv
module byte_lane_lsu_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_word, req_signed;
  logic [2:0]  base_idx;
  logic [15:0] base_val;
  logic [7:0]  disp;
  logic [15:0] st_data;
  logic        mem_en, mem_we;
  logic [1:0]  mem_be;
  logic [14:0] mem_waddr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] eff_addr;
  logic        misalign_fault, ld_valid;
  logic [15:0] ld_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic        we;
    logic [1:0]  be;
    logic [14:0] wa;
    logic [15:0] wd;
    logic [15:0] ea;
    string       tag;
  } cmd_t;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  cmd_t cmd_q[$];
  exp_t flt_q[$];
  exp_t ld_q[$];

  logic [7:0]  shadow [512];
  logic [15:0] ram    [256];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  byte_lane_lsu dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_word       (req_word),
    .req_signed     (req_signed),
    .base_idx       (base_idx),
    .base_val       (base_val),
    .disp           (disp),
    .st_data        (st_data),
    .mem_en         (mem_en),
    .mem_we         (mem_we),
    .mem_be         (mem_be),
    .mem_waddr      (mem_waddr),
    .mem_wdata      (mem_wdata),
    .mem_rdata      (mem_rdata),
    .eff_addr       (eff_addr),
    .misalign_fault (misalign_fault),
    .ld_valid       (ld_valid),
    .ld_data        (ld_data)
  );

  // Synchronous RAM with byte enables and one cycle of read latency.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) ram[mem_waddr[7:0]][7:0]  = mem_wdata[7:0];
        if (mem_be[1]) ram[mem_waddr[7:0]][15:8] = mem_wdata[15:8];
      end else begin
        mem_rdata <= ram[mem_waddr[7:0]];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issues one request and records what must follow.
  task automatic issue(input bit wr, input bit wd, input bit sx, input logic [2:0] idx,
                       input logic [15:0] base, input logic [7:0] d,
                       input logic [15:0] src, input string tag);
    logic [15:0] b, ea;
    logic [8:0]  a;
    cmd_t        c;
    exp_t        e;
    b  = (idx == 3'd0) ? 16'h0 : base;
    ea = b + {{8{d[7]}}, d};
    a  = ea[8:0];
    if (wd && ea[0]) begin
      e.val = ea; e.tag = tag;
      flt_q.push_back(e);
    end else begin
      c.we  = wr;
      c.be  = wd ? 2'b11 : (ea[0] ? 2'b10 : 2'b01);
      c.wa  = ea[15:1];
      c.wd  = wd ? src : {src[7:0], src[7:0]};
      c.ea  = ea;
      c.tag = tag;
      cmd_q.push_back(c);
      if (wr) begin
        shadow[a] = src[7:0];
        if (wd) shadow[a + 9'd1] = src[15:8];
      end else begin
        if (wd) e.val = {shadow[a + 9'd1], shadow[a]};
        else    e.val = {(sx ? {8{shadow[a][7]}} : 8'h00), shadow[a]};
        e.tag = tag;
        ld_q.push_back(e);
      end
    end
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_word   = wd;
    req_signed = sx;
    base_idx   = idx;
    base_val   = base;
    disp       = d;
    st_data    = src;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: pops expectations as the design produces results.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (mem_en) begin
          if (cmd_q.size() == 0) begin
            check(1'b0, "R8 unexpected memory strobe", {48'h0, eff_addr}, 64'h0);
          end else begin
            cmd_t c;
            bit ok;
            c  = cmd_q.pop_front();
            ok = (mem_we == c.we) && (mem_be == c.be) && (mem_waddr == c.wa) &&
                 (eff_addr == c.ea) && (!c.we || mem_wdata == c.wd);
            check(ok, c.tag,
                  {13'h0, mem_we, mem_be, 1'b0, mem_waddr, eff_addr, mem_wdata},
                  {13'h0, c.we, c.be, 1'b0, c.wa, c.ea, c.we ? c.wd : mem_wdata});
          end
        end
        if (misalign_fault) begin
          if (flt_q.size() == 0) begin
            check(1'b0, "R8 unexpected fault", {48'h0, eff_addr}, 64'h0);
          end else begin
            exp_t e;
            e = flt_q.pop_front();
            check(eff_addr == e.val && !mem_en, e.tag, {47'h0, mem_en, eff_addr},
                  {48'h0, e.val});
          end
        end
        if (ld_valid) begin
          if (ld_q.size() == 0) begin
            check(1'b0, "R9 unexpected load result", {48'h0, ld_data}, 64'h0);
          end else begin
            exp_t e;
            e = ld_q.pop_front();
            check(ld_data == e.val, e.tag, {48'h0, ld_data}, {48'h0, e.val});
          end
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) shadow[i] = 8'h00;
    for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
    mem_rdata  = 16'h0;
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_word   = 1'b0;
    req_signed = 1'b0;
    base_idx   = 3'd0;
    base_val   = 16'h0;
    disp       = 8'h0;
    st_data    = 16'h0;
    repeat (3) @(negedge clk);
    // R10: outputs idle during reset.
    check(!mem_en && !mem_we && mem_be == 2'b00 && !misalign_fault && !ld_valid &&
          eff_addr == 16'h0, "R10 reset state",
          {42'h0, mem_en, mem_we, mem_be, misalign_fault, ld_valid, eff_addr},
          64'h0);
    rst_n = 1'b1;
    idle(2);

    // R4, R1: word store through register-indirect (zero displacement).
    issue(1, 1, 0, 3'd3, 16'h0100, 8'h00, 16'hBEEF, "R4 word store indirect");
    // R7: read it back.
    issue(0, 1, 0, 3'd3, 16'h0100, 8'h00, 16'h0, "R7 word load");
    // R3: byte stores into both lanes of the next word.
    issue(1, 0, 0, 3'd2, 16'h0100, 8'h03, 16'h12A5, "R3 byte store high lane");
    issue(1, 0, 0, 3'd2, 16'h0100, 8'h02, 16'h3477, "R3 byte store low lane");
    // R5, R6: byte loads from each lane.
    issue(0, 0, 0, 3'd2, 16'h0100, 8'h03, 16'h0, "R5 unsigned byte load high lane");
    issue(0, 0, 1, 3'd2, 16'h0100, 8'h03, 16'h0, "R6 signed byte load negative");
    issue(0, 0, 1, 3'd2, 16'h0100, 8'h02, 16'h0, "R6 signed byte load positive");
    issue(0, 0, 0, 3'd3, 16'h0100, 8'h01, 16'h0, "R5 unsigned byte load from word");
    issue(0, 1, 0, 3'd2, 16'h0100, 8'h02, 16'h0, "R7 word load after byte stores");
    // R8: misaligned word accesses.
    issue(0, 1, 0, 3'd1, 16'h0100, 8'h01, 16'h0, "R8 odd word load faults");
    issue(1, 1, 0, 3'd1, 16'h0103, 8'h00, 16'hDEAD, "R8 odd word store faults");
    // R8: byte accesses at odd addresses are legal.
    issue(0, 0, 1, 3'd1, 16'h0103, 8'h00, 16'h0, "R8 odd byte load no fault");
    idle(4);
    // R2: zero base register ignores the value presented.
    issue(1, 1, 0, 3'd0, 16'h5555, 8'h10, 16'hC3C3, "R2 absolute word store");
    issue(0, 1, 0, 3'd0, 16'hAAAA, 8'h10, 16'h0, "R2 absolute word load");
    // R1: negative displacement and wrap-around.
    issue(1, 1, 0, 3'd4, 16'h0120, 8'h80, 16'h0F0F, "R1 negative displacement store");
    issue(0, 1, 0, 3'd5, 16'h00A2, 8'hFE, 16'h0, "R1 negative displacement load");
    issue(1, 0, 0, 3'd6, 16'hFFF0, 8'h21, 16'h0081, "R1 wrap-around byte store");
    issue(0, 0, 1, 3'd6, 16'hFFF0, 8'h21, 16'h0, "R1 wrap-around signed load");
    issue(1, 1, 0, 3'd0, 16'h1234, 8'hFE, 16'h7E81, "R1 absolute top of space");
    issue(0, 0, 0, 3'd0, 16'h0000, 8'hFF, 16'h0, "R5 byte load at 0xFFFF");
    issue(0, 0, 1, 3'd0, 16'h0000, 8'hFE, 16'h0, "R6 byte load at 0xFFFE");
    // R9: back-to-back traffic mixing all kinds.
    for (int i = 0; i < 8; i++) begin
      issue(1, i[0], 0, 3'd7, 16'h0040, 8'(2 * i), 16'h9000 + 16'(i * 16'h0111),
            "R9 burst store");
      issue(0, 0, i[1], 3'd7, 16'h0040, 8'(2 * i + 1), 16'h0, "R9 burst byte load");
      issue(0, 1, 0, 3'd7, 16'h0040, 8'(2 * i + 1), 16'h0, "R8 burst odd word");
    end
    idle(6);

    done = 1;
    check(cmd_q.size() == 0 && flt_q.size() == 0 && ld_q.size() == 0,
          "R9 all expected results seen", 64'(cmd_q.size() + flt_q.size() + ld_q.size()),
          64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule